// File: doc/BRIEF.md
# Lossless Edge Capture Interrupt Port

This block is an eight-input parallel port seen by software as a small register slave with single-cycle access. Each input line may change at any time with respect to the bus clock. The port brings each line into the clock domain and watches it for rising edges. A rising edge sets a sticky capture bit for that line. A mask selects which capture bits may raise the interrupt line.

Software acknowledges edges by writing ones to the capture register. Only the bit positions written as one are cleared, and the read-modify-write happens inside the block in a single cycle. An edge that lands in the same cycle as its own clear still leaves its bit set. A handler can therefore read the capture bits, write back exactly what it read, and never lose an edge that arrived in between.

Top module: `edgeirq_port`

## Requirements
- R1: Every input passes through a two-stage synchronizer. Offset 0 reads the synchronized inputs, so a change on `pin_in` shows at offset 0 two clock edges later and not after one.
- R2: A capture bit is set when the synchronized input is high and its previous synchronized sample was low. The bit reads as one at offset 3 three edges after the input rises. A falling edge or an input held high sets nothing.
- R3: A write to offset 3 clears exactly the capture bits written as one, in one cycle. Every other capture bit keeps its value.
- R4: If a rising edge on an input is detected in the same cycle as a write that clears that bit, the bit stays one and the interrupt stays raised.
- R5: `irq` is a register equal to the OR of (mask AND capture) from the previous cycle. It changes one edge after the mask or capture change that causes it. Capture bits still record edges while masked.
- R6: Offset 2 is a read/write mask in which bit i enables input i. Writing 0xFF enables all eight inputs.
- R7: A write to offset 0 has no effect. A capture write with all-zero data has no effect. Offset 1 reads as zero.
- R8: While `rst_n` is low at a clock edge, the mask, the capture bits, the previous-sample state and `irq` are cleared. An input that is already high when reset ends is not captured as an edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 8 | Asynchronous input lines |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, same cycle |
| irq | output | 1 | Registered interrupt request |

## Verification
The main function is driven by a sequence of pulse patterns: single lines, several lines at once, all eight lines, and no lines. Each pattern is paired with a different mask and a different acknowledge value. A partial clear that touches the wrong bits, or an interrupt that ignores the mask, leaves a different accumulated capture value or `irq` level. Separate directed steps tell apart the one-edge and two-edge latency points, a falling edge from a rising one, and an input high across reset from a true edge. A set that collides with its clear in the same cycle is checked against an ordinary clear.

// File: rtl/edgeirq_pkg.sv
// Shared definitions for the edge capture interrupt port.
// Assumes a two-bit word offset on the register bus.
package edgeirq_pkg;
    localparam int REG_ADDR_W = 2;

    // Register offsets; software depends on these positions.
    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_DATA = 2'd0,
        SEL_RSVD = 2'd1,
        SEL_MASK = 2'd2,
        SEL_CAP  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/edgeirq_sync.sv
// Multi-stage synchronizer for a bus of independent asynchronous lines.
// Assumes each line is treated on its own (no bus coherency is implied).
module edgeirq_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    // Purpose: shift the raw lines through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
        end else begin
            stg_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/edgeirq_capture.sv
// Rising-edge detector with sticky per-bit capture and write-one-to-clear.
// Assumes sync_i is already in the clock domain; a set beats a clear.
// Capture is held off after reset until the synchronizer carries real samples.
module edgeirq_capture #(
    parameter int W    = 8,
    parameter int WARM = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] cap_o
);
    localparam int               CNT_W    = $clog2(WARM + 1);
    localparam logic [CNT_W-1:0] WARM_END = CNT_W'(WARM);

    logic [CNT_W-1:0] warm_q;
    logic             armed;
    logic [W-1:0]     prev_q;
    logic [W-1:0]     cap_q;
    logic [W-1:0]     rise;
    logic [W-1:0]     cap_d;

    assign armed = (warm_q == WARM_END);

    // Purpose: count edges after reset until the sample pipeline is filled.
    always_ff @(posedge clk) begin
        if (!rst_n)      warm_q <= '0;
        else if (!armed) warm_q <= warm_q + 1'b1;
    end

    // Purpose: keep the previous synchronized sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_i;
    end

    // Purpose: detect rising edges once armed.
    always_comb begin
        rise = armed ? (sync_i & ~prev_q) : '0;
    end

    // Purpose: next capture value, the clear applied first and the set on top.
    always_comb begin
        cap_d = (cap_q & ~clr_i) | rise;
    end

    // Purpose: hold the sticky capture bits.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign cap_o = cap_q;

    // R4
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((cap_q & $past(rise)) == $past(rise)));

    // R2
    rise_only_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 ((cap_q & ~$past(cap_q) & ~$past(rise)) == '0));

    // R3
    clear_only_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 (($past(cap_q) & ~cap_q & ~$past(clr_i)) == '0));

    // R8
    quiet_until_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (cap_q == '0));
endmodule

// File: rtl/edgeirq_regs.sv
// Register slave: mask storage, capture clear strobes and read multiplexer.
// Assumes single-cycle writes and a combinational read on the current offset.
module edgeirq_regs
    import edgeirq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] addr_i,
    input  logic                  wr_i,
    input  logic [W-1:0]          wdata_i,
    input  logic [W-1:0]          sync_i,
    input  logic [W-1:0]          cap_i,
    output logic [W-1:0]          mask_o,
    output logic [W-1:0]          clr_o,
    output logic [W-1:0]          rdata_o
);
    reg_sel_e     sel;
    logic [W-1:0] mask_q;

    assign sel = reg_sel_e'(addr_i);

    // Purpose: store the interrupt mask.
    always_ff @(posedge clk) begin
        if (!rst_n)                       mask_q <= '0;
        else if (wr_i && sel == SEL_MASK) mask_q <= wdata_i;
    end

    // Purpose: turn a capture write into per-bit clear strobes.
    always_comb begin
        clr_o = (wr_i && sel == SEL_CAP) ? wdata_i : '0;
    end

    // Purpose: select read data by offset.
    always_comb begin
        case (sel)
            SEL_DATA: rdata_o = sync_i;
            SEL_MASK: rdata_o = mask_q;
            SEL_CAP:  rdata_o = cap_i;
            default:  rdata_o = '0;
        endcase
    end

    assign mask_o = mask_q;

    // R6
    mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel == SEL_MASK) |=> (mask_q == $past(wdata_i)));

    // R7
    data_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel == SEL_DATA) |=> $stable(mask_q));
endmodule

// File: rtl/edgeirq_port.sv
// Top of the edge capture interrupt port: synchronizer, capture, registers
// and the registered interrupt output. Assumes inputs are asynchronous.
module edgeirq_port
    import edgeirq_pkg::*;
#(
    parameter int NUM_IN      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_IN-1:0]     pin_in,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic [NUM_IN-1:0]     bus_wdata,
    output logic [NUM_IN-1:0]     bus_rdata,
    output logic                  irq
);
    localparam int WARM_CYCLES = SYNC_STAGES + 1;

    logic [NUM_IN-1:0] sync_w;
    logic [NUM_IN-1:0] cap_w;
    logic [NUM_IN-1:0] mask_w;
    logic [NUM_IN-1:0] clr_w;
    logic              irq_q;

    edgeirq_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_in),
        .q_o   (sync_w)
    );

    edgeirq_capture #(.W(NUM_IN), .WARM(WARM_CYCLES)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_w),
        .clr_i  (clr_w),
        .cap_o  (cap_w)
    );

    edgeirq_regs #(.W(NUM_IN)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (bus_addr),
        .wr_i    (bus_wr),
        .wdata_i (bus_wdata),
        .sync_i  (sync_w),
        .cap_i   (cap_w),
        .mask_o  (mask_w),
        .clr_o   (clr_w),
        .rdata_o (bus_rdata)
    );

    // Purpose: register the interrupt from the masked capture bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(mask_w & cap_w);
    end

    assign irq = irq_q;

    // R5
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past((mask_w & cap_w) != '0));

    // R5
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask_w & cap_w) == '0) |=> !irq_q);
endmodule

// File: tb/edgeirq_port_tb.sv
`timescale 1ns/1ps
module edgeirq_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_in = 8'h81;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_run = 0;
    int n_fail = 0;

    // Each entry: {mask, pulse pattern, acknowledge value}
    localparam logic [23:0] VEC [8] = '{
        {8'hFF, 8'h01, 8'h00},
        {8'hFF, 8'h82, 8'h01},
        {8'h0F, 8'h3C, 8'h80},
        {8'h00, 8'h40, 8'h00},
        {8'hF0, 8'h00, 8'h0E},
        {8'h10, 8'h00, 8'h60},
        {8'h01, 8'h11, 8'hFF},
        {8'hFF, 8'hFF, 8'hAA}
    };

    edgeirq_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #2 clk = ~clk;

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        tick(1);
        bus_wr    = 1'b0;
        bus_wdata = 8'h00;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic pulse(input logic [7:0] pat);
        pin_in = pat;
        tick(4);
        pin_in = 8'h00;
        tick(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] exp_cap;
        tick(4);
        rst_n = 1'b1;
        // R8: reset state of every register and irq
        rd_reg(2'd2, v); chk("R8 mask after reset", v, 8'h00);
        rd_reg(2'd3, v); chk("R8 capture after reset", v, 8'h00);
        chk("R8 irq after reset", {7'd0, irq}, 8'h00);
        tick(8);
        // R8: lines high across reset are not edges
        rd_reg(2'd3, v); chk("R8 no capture of level at reset", v, 8'h00);
        rd_reg(2'd0, v); chk("R1 data shows lines", v, 8'h81);
        pin_in = 8'h00;
        tick(6);
        rd_reg(2'd3, v); chk("R2 falling edge ignored", v, 8'h00);

        // R1 / R2 latency
        pin_in = 8'h04;
        tick(1);
        rd_reg(2'd0, v); chk("R1 not visible after one edge", v, 8'h00);
        tick(1);
        rd_reg(2'd0, v); chk("R1 visible after two edges", v, 8'h04);
        rd_reg(2'd3, v); chk("R2 not captured after two edges", v, 8'h00);
        tick(1);
        rd_reg(2'd3, v); chk("R2 captured after three edges", v, 8'h04);
        // R5 latency of irq after the mask write
        wr_reg(2'd2, 8'h04);
        chk("R5 irq not yet", {7'd0, irq}, 8'h00);
        tick(1);
        chk("R5 irq one edge after mask", {7'd0, irq}, 8'h01);
        rd_reg(2'd2, v); chk("R6 mask readback", v, 8'h04);
        wr_reg(2'd3, 8'h04);
        rd_reg(2'd3, v); chk("R3 clear single bit", v, 8'h00);
        tick(5);
        rd_reg(2'd3, v); chk("R2 held level sets nothing", v, 8'h00);
        pin_in = 8'h00;
        tick(4);

        // Table walk: accumulate, acknowledge, check capture and irq
        exp_cap = 8'h00;
        for (int k = 0; k < 8; k++) begin
            wr_reg(2'd2, VEC[k][23:16]);
            pulse(VEC[k][15:8]);
            exp_cap = exp_cap | VEC[k][15:8];
            rd_reg(2'd3, v); chk("R2 capture accumulates", v, exp_cap);
            wr_reg(2'd3, VEC[k][7:0]);
            exp_cap = exp_cap & ~VEC[k][7:0];
            tick(2);
            rd_reg(2'd3, v); chk("R3 partial clear", v, exp_cap);
            chk("R5 irq from mask and capture", {7'd0, irq},
                {7'd0, |(VEC[k][23:16] & exp_cap)});
        end

        // R7: writes to data offset and zero acknowledge have no effect
        wr_reg(2'd0, 8'h3C);
        tick(1);
        rd_reg(2'd2, v); chk("R7 data write leaves mask", v, 8'hFF);
        rd_reg(2'd3, v); chk("R7 data write leaves capture", v, 8'h55);
        rd_reg(2'd0, v); chk("R7 data still shows lines", v, 8'h00);
        wr_reg(2'd3, 8'h00);
        rd_reg(2'd3, v); chk("R7 zero clear ignored", v, 8'h55);
        rd_reg(2'd1, v); chk("R7 offset 1 reads zero", v, 8'h00);

        // R4: a new edge in the same cycle as its clear survives
        wr_reg(2'd3, 8'hFF);
        pulse(8'h28);
        wr_reg(2'd2, 8'h08);
        rd_reg(2'd3, v); chk("R4 setup", v, 8'h28);
        pin_in = 8'h08;
        tick(2);
        wr_reg(2'd3, 8'h28);
        rd_reg(2'd3, v); chk("R4 set wins over clear", v, 8'h08);
        tick(1);
        chk("R4 irq stays raised", {7'd0, irq}, 8'h01);
        pin_in = 8'h00;
        tick(4);

        // R5 / R6: masked capture still records, full mask enables it
        wr_reg(2'd2, 8'h00);
        wr_reg(2'd3, 8'hFF);
        pulse(8'h01);
        rd_reg(2'd3, v); chk("R5 masked edge recorded", v, 8'h01);
        chk("R5 masked irq low", {7'd0, irq}, 8'h00);
        wr_reg(2'd2, 8'hFF);
        tick(1);
        chk("R6 full mask raises irq", {7'd0, irq}, 8'h01);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule